// File: doc/BRIEF.md
# Masked Start-Code Scanner

This block watches a byte stream arriving over a valid/ready interface and looks for a 32-bit marker. Each accepted byte enters a four-byte sliding window, newest byte in the low lane. The window is compared with a programmable pattern, and only the bits set in a programmable mask take part. A hit sets a sticky status flag. The flag is cleared by writing a one to it. An interrupt line follows the flag only while a separate host-enable bit is set. When forwarding is on, every accepted byte, the marker bytes included, is passed in order to a downstream FIFO write port. When forwarding is off, bytes are consumed and dropped.

By default the pattern is 0x00000100 and the mask is 0xFFFFFF00, so any 00 00 01 xx run counts as a hit. Software normally appends 00 00 01 FF after a payload so that the end of the packet raises an interrupt.

A three-state machine sets the flow:
- ST_IDLE: the engine is stopped and `in_ready` is low.
- ST_FILL: fewer than four bytes have arrived since start, and no hit can be flagged.
- ST_SCAN: the window is full and every accepted byte is compared.

The transitions are:
- IDLE→FILL when the start bit is set. The window and the fill count are cleared on this transition.
- FILL→SCAN on the fourth accepted byte.
- FILL→IDLE and SCAN→IDLE when the start bit is cleared. The window keeps its contents.

Top module: `sc_scan_engine`

## Requirements
- R1: After reset the registers read as follows: control 0 (address 0), pattern 0x00000100 (address 1), mask 0xFFFFFF00 (address 2), interrupt enable 0 (address 3), status 0 (address 4) and window 0 (address 5). After reset `irq` and `in_ready` are 0.
- R2: While control bit 0 (start) is 0, `in_ready` and `fifo_wr_en` stay 0, even when `in_valid` is 1.
- R3: When control bit 5 (forward enable) is 1, each accepted byte drives `fifo_wr_en`=1 with `fifo_wr_data` equal to that byte in the same cycle. When bit 5 is 0, `fifo_wr_en` stays 0 and bytes are still accepted.
- R4: When forwarding is enabled and `fifo_full` is 1, `in_ready` is 0. When forwarding is disabled, `fifo_full` does not affect `in_ready`.
- R5: On each accepted byte the window shifts left by 8 bits and takes the byte into bits 7:0. The window reads back at address 5. A hit occurs when ((window ^ pattern) & mask) == 0.
- R6: Setting start clears the window to 0. No hit is flagged until the fourth byte accepted since start.
- R7: Status bit 0 is set on the edge that accepts a hitting byte. It holds until a write to address 4 with data bit 0 set. If a hit and a clear fall in the same cycle, the hit wins.
- R8: `irq` equals status bit 0 AND interrupt-enable bit 8.
- R9: While control bit 1 (search enable) is 0, no hit is flagged, but bytes are still accepted.
- R10: Clearing start stops acceptance at once and the window contents are held.
- R11: Control bits 23:8 hold a packet-size field. Control reads back bits 0, 1, 5 and 23:8 as written, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with valid |
| in_data | input | 8 | Input byte |
| fifo_wr_en | output | 1 | Downstream FIFO write strobe |
| fifo_wr_data | output | 8 | Downstream FIFO write byte |
| fifo_full | input | 1 | Downstream FIFO full |
| irq | output | 1 | Interrupt to host |

## Verification
The assertions check the following on every cycle:
- the engine stays silent while stopped;
- the stall under a full FIFO when forwarding;
- that search-off suppresses hits;
- the sticky behaviour of the status flag;
- that a hit always sets it;
- that the window is held when nothing shifts and is zeroed on start.

Only the bench scenarios can show:
- which byte sequences actually hit under a given pattern and mask;
- the four-byte arming delay;
- byte order on the FIFO port;
- read-back values;
- the hit-over-clear priority when both fall on one edge.

The bench sweeps all 256 byte values through two pattern/mask setups.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int REG_W = 32;

    localparam int A_CTRL  = 0;
    localparam int A_PAT   = 1;
    localparam int A_MASK  = 2;
    localparam int A_IEN   = 3;
    localparam int A_ISTAT = 4;
    localparam int A_WIN   = 5;

    localparam int CB_START  = 0;
    localparam int CB_SEARCH = 1;
    localparam int CB_FWD    = 5;
    localparam int CB_PKT    = 8;
    localparam int IEN_HOST  = 8;

    localparam logic [REG_W-1:0] PAT_RESET  = 32'h0000_0100;
    localparam logic [REG_W-1:0] MASK_RESET = 32'hFFFF_FF00;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SCAN = 2'd2
    } scan_state_e;
endpackage

// File: rtl/sc_cfg_regs.sv
module sc_cfg_regs
    import sc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int PKT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              hit_i,
    input  logic [REG_W-1:0]  win_i,
    output logic              start_o,
    output logic              search_o,
    output logic              fwd_o,
    output logic [REG_W-1:0]  pattern_o,
    output logic [REG_W-1:0]  mask_o,
    output logic              host_en_o,
    output logic              found_o
);
    logic             start_q, search_q, fwd_q, host_en_q, found_q;
    logic [PKT_W-1:0] pkt_q;
    logic [REG_W-1:0] pat_q, mask_q;
    logic             wr_ctrl, wr_pat, wr_mask, wr_ien, clr_found;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_pat    = reg_wr && (reg_addr == ADDR_W'(A_PAT));
    assign wr_mask   = reg_wr && (reg_addr == ADDR_W'(A_MASK));
    assign wr_ien    = reg_wr && (reg_addr == ADDR_W'(A_IEN));
    assign clr_found = reg_wr && (reg_addr == ADDR_W'(A_ISTAT)) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            search_q  <= 1'b0;
            fwd_q     <= 1'b0;
            pkt_q     <= '0;
            pat_q     <= PAT_RESET;
            mask_q    <= MASK_RESET;
            host_en_q <= 1'b0;
            found_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                start_q  <= reg_wdata[CB_START];
                search_q <= reg_wdata[CB_SEARCH];
                fwd_q    <= reg_wdata[CB_FWD];
                pkt_q    <= reg_wdata[CB_PKT +: PKT_W];
            end
            if (wr_pat)  pat_q     <= reg_wdata;
            if (wr_mask) mask_q    <= reg_wdata;
            if (wr_ien)  host_en_q <= reg_wdata[IEN_HOST];
            found_q <= hit_i | (found_q & ~clr_found);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CTRL): begin
                reg_rdata[CB_START]         = start_q;
                reg_rdata[CB_SEARCH]        = search_q;
                reg_rdata[CB_FWD]           = fwd_q;
                reg_rdata[CB_PKT +: PKT_W]  = pkt_q;
            end
            ADDR_W'(A_PAT):   reg_rdata = pat_q;
            ADDR_W'(A_MASK):  reg_rdata = mask_q;
            ADDR_W'(A_IEN):   reg_rdata[IEN_HOST] = host_en_q;
            ADDR_W'(A_ISTAT): reg_rdata[0] = found_q;
            ADDR_W'(A_WIN):   reg_rdata = win_i;
            default:          reg_rdata = '0;
        endcase
    end

    assign start_o   = start_q;
    assign search_o  = search_q;
    assign fwd_o     = fwd_q;
    assign pattern_o = pat_q;
    assign mask_o    = mask_q;
    assign host_en_o = host_en_q;
    assign found_o   = found_q;

    // R7: flag is sticky unless a one is written to it
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (found_q && !clr_found) |=> found_q);
    // R7: a hit always leaves the flag set
    p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> found_q);
endmodule

// File: rtl/sc_window_match.sv
module sc_window_match #(
    parameter int WIN_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              armed_i,
    input  logic              search_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [WIN_W-1:0]  pattern_i,
    input  logic [WIN_W-1:0]  mask_i,
    output logic              hit_o,
    output logic [WIN_W-1:0]  win_o
);
    localparam int LANES = WIN_W / BYTE_W;

    logic [WIN_W-1:0] win_q, win_next;
    logic [LANES-1:0] lane_eq;

    assign win_next = {win_q[WIN_W-BYTE_W-1:0], byte_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_q <= '0;
        else if (clear_i) win_q <= '0;
        else if (shift_i) win_q <= win_next;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (((win_next[g*BYTE_W +: BYTE_W] ^ pattern_i[g*BYTE_W +: BYTE_W])
                              & mask_i[g*BYTE_W +: BYTE_W]) == '0);
    end

    assign hit_o = shift_i && armed_i && search_i && (&lane_eq);
    assign win_o = win_q;

    // R10: window is held when no byte shifts in
    p_win_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clear_i) |=> $stable(win_q));
    // R6: start clears the window
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (win_q == '0));
endmodule

// File: rtl/sc_scan_fsm.sv
module sc_scan_fsm
    import sc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fwd_i,
    input  logic in_valid_i,
    input  logic fifo_full_i,
    output logic in_ready_o,
    output logic accept_o,
    output logic clear_o,
    output logic armed_o,
    output logic fifo_we_o
);
    localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] fill_q;
    logic             last_fill;

    assign last_fill = (fill_q == CNT_W'(DEPTH-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_FILL;
            ST_FILL: begin
                if (!start_i)                    state_d = ST_IDLE;
                else if (accept_o && last_fill)  state_d = ST_SCAN;
            end
            ST_SCAN: if (!start_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready_o = 1'b0;
        clear_o    = 1'b0;
        armed_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: clear_o = start_i;
            ST_FILL: begin
                in_ready_o = start_i && !(fwd_i && fifo_full_i);
                armed_o    = last_fill;
            end
            ST_SCAN: begin
                in_ready_o = start_i && !(fwd_i && fifo_full_i);
                armed_o    = 1'b1;
            end
            default: ;
        endcase
        accept_o  = in_valid_i && in_ready_o;
        fifo_we_o = accept_o && fwd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               fill_q <= '0;
        else if (clear_o)                         fill_q <= '0;
        else if (state_q == ST_FILL && accept_o)  fill_q <= fill_q + 1'b1;
    end
endmodule

// File: rtl/sc_scan_engine.sv
module sc_scan_engine
    import sc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BYTE_W = 8,
    parameter int PKT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              fifo_wr_en,
    output logic [BYTE_W-1:0] fifo_wr_data,
    input  logic              fifo_full,
    output logic              irq
);
    localparam int DEPTH = REG_W / BYTE_W;

    logic             start, search, fwd, host_en, found;
    logic             accept, clear, armed, hit;
    logic [REG_W-1:0] pattern, mask, win;

    sc_cfg_regs #(.ADDR_W(ADDR_W), .PKT_W(PKT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit_i     (hit),
        .win_i     (win),
        .start_o   (start),
        .search_o  (search),
        .fwd_o     (fwd),
        .pattern_o (pattern),
        .mask_o    (mask),
        .host_en_o (host_en),
        .found_o   (found)
    );

    sc_scan_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .fwd_i       (fwd),
        .in_valid_i  (in_valid),
        .fifo_full_i (fifo_full),
        .in_ready_o  (in_ready),
        .accept_o    (accept),
        .clear_o     (clear),
        .armed_o     (armed),
        .fifo_we_o   (fifo_wr_en)
    );

    sc_window_match #(.WIN_W(REG_W), .BYTE_W(BYTE_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .shift_i   (accept),
        .armed_i   (armed),
        .search_i  (search),
        .byte_i    (in_data),
        .pattern_i (pattern),
        .mask_i    (mask),
        .hit_o     (hit),
        .win_o     (win)
    );

    assign fifo_wr_data = in_data;
    assign irq          = found && host_en;

    // R2: stopped engine neither accepts nor forwards
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> (!in_ready && !fifo_wr_en));
    // R4: forwarding into a full FIFO stalls the input
    p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && fifo_full) |-> !in_ready);
    // R9: search disabled means no hit
    p_search_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !search |-> !hit);
endmodule

// File: tb/test_sc_scan_engine.sv
`timescale 1ns/1ps
module test_sc_scan_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        fifo_wr_en;
    logic [7:0]  fifo_wr_data;
    logic        fifo_full = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sc_scan_engine i_sc_scan_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [7:0] b, input logic fwd_exp);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        check("R3 fifo_wr_en", {31'd0, fifo_wr_en}, {31'd0, fwd_exp});
        if (fwd_exp) check("R3 fifo_wr_data", {24'd0, fifo_wr_data}, {24'd0, b});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic restart(input logic [31:0] ctrl);
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd4, 32'd1);
        wr_reg(3'd0, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act hung exp done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd0, r); check("R1 ctrl", r, 32'h0);
        rd_reg(3'd1, r); check("R1 pattern", r, 32'h0000_0100);
        rd_reg(3'd2, r); check("R1 mask", r, 32'hFFFF_FF00);
        rd_reg(3'd3, r); check("R1 ien", r, 32'h0);
        rd_reg(3'd4, r); check("R1 status", r, 32'h0);
        rd_reg(3'd5, r); check("R1 window", r, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd0);

        // R11 control readback without start
        wr_reg(3'd0, 32'hFFFF_FFFE);
        rd_reg(3'd0, r); check("R11 ctrl readback", r, 32'h00FF_FF22);
        wr_reg(3'd0, 32'h0);

        // R2 stopped engine ignores valid
        @(negedge clk); in_valid = 1'b1; in_data = 8'h00;
        repeat (3) begin
            @(negedge clk); #1;
            check("R2 in_ready idle", {31'd0, in_ready}, 32'd0);
            check("R2 fifo_wr_en idle", {31'd0, fifo_wr_en}, 32'd0);
        end
        in_valid = 1'b0;

        // R5/R8 sweep A: default pattern/mask, bytes {v,00,01,v}, hit iff v==0, irq masked
        for (int v = 0; v < 256; v++) begin
            restart(32'h3);
            send(8'(v), 1'b0); send(8'h00, 1'b0); send(8'h01, 1'b0); send(8'(v), 1'b0);
            e = (v == 0);
            rd_reg(3'd4, r); check("R5 sweep A status", r, {31'd0, e});
            check("R8 irq masked", {31'd0, irq}, 32'd0);
        end
        rd_reg(3'd5, r); check("R5 window order", r, 32'hFF00_01FF);

        // R5/R8 sweep B: exact 000001FF, host enable on, hit iff v==FF
        wr_reg(3'd1, 32'h0000_01FF);
        wr_reg(3'd2, 32'hFFFF_FFFF);
        wr_reg(3'd3, 32'h0000_0100);
        for (int v = 0; v < 256; v++) begin
            restart(32'h3);
            send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h01, 1'b0); send(8'(v), 1'b0);
            e = (v == 255);
            rd_reg(3'd4, r); check("R5 sweep B status", r, {31'd0, e});
            check("R8 irq follows status", {31'd0, irq}, {31'd0, e});
        end
        wr_reg(3'd4, 32'h1);
        check("R8 irq cleared", {31'd0, irq}, 32'd0);

        // R6 no hit before four bytes, even with mask 0
        wr_reg(3'd2, 32'h0);
        restart(32'h3);
        rd_reg(3'd5, r); check("R6 window cleared on start", r, 32'h0);
        send(8'hAA, 1'b0); send(8'hBB, 1'b0); send(8'hCC, 1'b0);
        rd_reg(3'd4, r); check("R6 no hit after 3 bytes", r, 32'h0);
        send(8'hDD, 1'b0);
        rd_reg(3'd4, r); check("R6 hit on 4th byte", r, 32'h1);
        rd_reg(3'd5, r); check("R5 window AABBCCDD", r, 32'hAABB_CCDD);

        // R7 sticky: writing 0 does not clear, writing 1 does
        wr_reg(3'd4, 32'h0);
        rd_reg(3'd4, r); check("R7 write 0 keeps", r, 32'h1);
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, r); check("R7 write 1 clears", r, 32'h0);

        // R7 hit and clear on the same edge: hit wins (engine in ST_SCAN, mask 0)
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h55;
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
        #1 check("R7 ready in scan", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0; reg_wr = 1'b0;
        rd_reg(3'd4, r); check("R7 hit beats clear", r, 32'h1);

        // R10 stop holds window and drops ready
        restart(32'h3);
        send(8'h12, 1'b0); send(8'h34, 1'b0);
        wr_reg(3'd0, 32'h2);
        @(negedge clk); in_valid = 1'b1; in_data = 8'h99;
        #1 check("R10 ready after stop", {31'd0, in_ready}, 32'd0);
        @(negedge clk); in_valid = 1'b0;
        rd_reg(3'd5, r); check("R10 window held", r, 32'h0000_1234);

        // R9 search disabled: bytes consumed, no hit
        restart(32'h1);
        send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h01, 1'b0); send(8'hFF, 1'b0);
        rd_reg(3'd4, r); check("R9 no hit when search off", r, 32'h0);
        rd_reg(3'd5, r); check("R9 bytes still shifted", r, 32'h0000_01FF);

        // R3 forwarding on: bytes pass in order (checked in send)
        wr_reg(3'd2, 32'hFFFF_FF00);
        wr_reg(3'd1, 32'h0000_0100);
        restart(32'h23);
        for (int k = 0; k < 8; k++) send(8'(k * 37 + 3), 1'b1);
        send(8'h00, 1'b1); send(8'h00, 1'b1); send(8'h01, 1'b1); send(8'hFF, 1'b1);
        rd_reg(3'd4, r); check("R3 trailer hit with forwarding", r, 32'h1);

        // R4 full FIFO stalls when forwarding
        @(negedge clk); fifo_full = 1'b1; in_valid = 1'b1; in_data = 8'h77;
        #1 check("R4 stall on full", {31'd0, in_ready}, 32'd0);
        check("R4 no write on full", {31'd0, fifo_wr_en}, 32'd0);
        @(negedge clk); in_valid = 1'b0;
        rd_reg(3'd5, r); check("R4 window unchanged", r, 32'h0000_01FF);
        wr_reg(3'd0, 32'h03);
        @(negedge clk); in_valid = 1'b1;
        #1 check("R4 full ignored without forwarding", {31'd0, in_ready}, 32'd1);
        check("R3 no write without forwarding", {31'd0, fifo_wr_en}, 32'd0);
        @(negedge clk); in_valid = 1'b0; fifo_full = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule